// File: doc/BRIEF.md
# Geometric-History Direction Predictor

This block guesses whether a conditional branch will be taken. A tagless table of 2-bit counters gives a fallback guess from the branch address alone. Three tagged banks refine it. Each tagged bank is indexed by a hash of the address and of a slice of recent branch outcomes. The slice lengths are 4, 8 and 16 outcomes, so each is twice the one before. A tagged bank takes part only when the partial tag stored at its indexed entry equals the tag computed for the current branch. When several banks take part, the one with the longest slice decides.

Fetch presents a word address on the lookup port. In the same cycle the block returns the guess, the code of the component that made it, and the outcome history it used. Once the branch resolves, the owner sends back the address, the saved history and the real outcome. The block then trains the deciding counter, marks entries that proved their worth, and claims entries in longer banks after a wrong guess. It also shifts the outcome into its own history register.

Top module: `geo_hist_predictor`

## Requirements
- R1: After reset every base counter is 1, every tagged counter is 3, every useful bit is 0, every stored tag is 0 and the history is 0. A lookup at word address 0x0ABC then gives lk_taken=0, lk_src=0 and lk_hist=0.
- R2: The base entry is indexed by pc[7:0]. It predicts taken when its 2-bit counter is 2 or 3. lk_src=0 means the base table made the guess.
- R3: fold(h,L,W) is a W-bit value whose bit j is the XOR of every h[k] with k<L and k mod W = j, where h[0] is the most recent outcome. Tagged bank t (1..3) uses L=4, 8 or 16. Its index is pc[5:0] ^ fold(h,L,6). Its tag is pc[13:6] ^ fold(h,L,7), zero-extended to 8 bits.
- R4: Bank t matches when its stored tag equals the computed tag. The matching bank with the largest t decides. lk_src=t, and the guess is taken when that bank's 3-bit counter is 4 or more.
- R5: The lookup is combinational over the table state and lk_hist equals the current history. A lookup made in the same cycle as an update sees the state from before that update.
- R6: On an update, only the deciding component's counter moves one step toward the outcome, saturating at 0 and at its maximum.
- R7: The deciding tagged entry's useful bit is set when its guess was right and differed from the guess of the next-longest matching bank (or of the base table when no other bank matches).
- R8: When the guess was wrong and a bank longer than the decider exists, the shortest such bank whose indexed useful bit is 0 is claimed. It receives the new tag, a counter of 4 for a taken outcome or 3 for a not-taken outcome, and a useful bit of 0.
- R9: If every such longer bank has its useful bit set, none is claimed and each of those useful bits is cleared.
- R10: When up_valid is 1 the history becomes {old[14:0], up_taken}. When up_valid is 0 the history holds.
- R11: A single branch whose outcome repeats taken, taken, taken, not-taken is predicted without error after warm-up from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 14 | Word address of the branch being fetched |
| lk_taken | output | 1 | Guessed direction, 1 = taken |
| lk_src | output | 2 | Component that guessed: 0 base, 1..3 tagged bank |
| lk_hist | output | 16 | History used for the lookup, to be returned on update |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | 14 | Word address of the resolved branch |
| up_hist | input | 16 | History snapshot taken at its lookup |
| up_taken | input | 1 | Resolved direction |

## Verification
Lookup and training share the tables, so they can fall in the same cycle. The bench drives a new lookup and the update of an earlier branch in the same cycle on every step, with equal and with different addresses. Every guess is judged against a reference model that evaluates the lookup before it applies that cycle's training. A mismatch in the guess, the deciding component or the history shows that a write leaked into the same-cycle read, or that the read used stale state.

// File: rtl/geo_pred_pkg.sv
package geo_pred_pkg;
   localparam int NUM_TAGGED = 3;
   typedef enum logic [1:0] {
      SRC_BASE = 2'd0,
      SRC_T1   = 2'd1,
      SRC_T2   = 2'd2,
      SRC_T3   = 2'd3
   } src_e;
endpackage

// File: rtl/geo_base_table.sv
module geo_base_table #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_pred,
   input  logic [IDX_W-1:0] wr_idx,
   output logic             wr_pred,
   input  logic             ctr_en,
   input  logic             ctr_up
);
   localparam int DEPTH = 1 << IDX_W;
   logic [1:0] ctr_q [DEPTH];

   assign rd_pred = ctr_q[rd_idx][1];
   assign wr_pred = ctr_q[wr_idx][1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) ctr_q[e] <= 2'd1;
      end else if (ctr_en) begin
         if (ctr_up && ctr_q[wr_idx] != 2'd3)
            ctr_q[wr_idx] <= ctr_q[wr_idx] + 2'd1;
         else if (!ctr_up && ctr_q[wr_idx] != 2'd0)
            ctr_q[wr_idx] <= ctr_q[wr_idx] - 2'd1;
      end
   end

   // support state for the saturation check
   logic             chk_en, chk_up;
   logic [IDX_W-1:0] chk_idx;
   logic [1:0]       chk_old;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_en <= 1'b0; chk_up <= 1'b0; chk_idx <= '0; chk_old <= '0;
      end else begin
         chk_en <= ctr_en; chk_up <= ctr_up; chk_idx <= wr_idx; chk_old <= ctr_q[wr_idx];
      end
   end

   p_base_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && chk_up && chk_old == 2'd3) |-> ctr_q[chk_idx] == 2'd3);
endmodule

// File: rtl/geo_tag_bank.sv
module geo_tag_bank #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 8,
   parameter int CTR_W = 3,
   parameter int HLEN  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W+TAG_W-1:0] rd_pc,
   input  logic [HLEN-1:0]        rd_hist,
   output logic                   rd_hit,
   output logic                   rd_pred,
   input  logic [IDX_W+TAG_W-1:0] wr_pc,
   input  logic [HLEN-1:0]        wr_hist,
   output logic                   wr_hit,
   output logic                   wr_pred,
   output logic                   wr_useful,
   input  logic                   ctr_en,
   input  logic                   ctr_up,
   input  logic                   u_set,
   input  logic                   u_clr,
   input  logic                   alloc_en,
   input  logic                   alloc_up
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = '1;
   localparam logic [CTR_W-1:0] CTR_WT  = CTR_W'(1 << (CTR_W - 1));
   localparam logic [CTR_W-1:0] CTR_WN  = CTR_W'((1 << (CTR_W - 1)) - 1);

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [DEPTH-1:0] u_q;

   function automatic logic [IDX_W-1:0] fold_idx(input logic [HLEN-1:0] h);
      logic [IDX_W-1:0] r = '0;
      for (int k = 0; k < HLEN; k++) r[k % IDX_W] = r[k % IDX_W] ^ h[k];
      return r;
   endfunction

   function automatic logic [TAG_W-2:0] fold_tag(input logic [HLEN-1:0] h);
      logic [TAG_W-2:0] r = '0;
      for (int k = 0; k < HLEN; k++) r[k % (TAG_W-1)] = r[k % (TAG_W-1)] ^ h[k];
      return r;
   endfunction

   logic [IDX_W-1:0] ri, wi;
   logic [TAG_W-1:0] rt, wt;
   assign ri = rd_pc[IDX_W-1:0] ^ fold_idx(rd_hist);
   assign wi = wr_pc[IDX_W-1:0] ^ fold_idx(wr_hist);
   assign rt = rd_pc[IDX_W+TAG_W-1:IDX_W] ^ {1'b0, fold_tag(rd_hist)};
   assign wt = wr_pc[IDX_W+TAG_W-1:IDX_W] ^ {1'b0, fold_tag(wr_hist)};

   assign rd_hit    = (tag_q[ri] == rt);
   assign rd_pred   = ctr_q[ri][CTR_W-1];
   assign wr_hit    = (tag_q[wi] == wt);
   assign wr_pred   = ctr_q[wi][CTR_W-1];
   assign wr_useful = u_q[wi];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            ctr_q[e] <= CTR_WN;
            tag_q[e] <= '0;
         end
         u_q <= '0;
      end else begin
         if (ctr_en) begin
            if (ctr_up && ctr_q[wi] != CTR_MAX)
               ctr_q[wi] <= ctr_q[wi] + 1'b1;
            else if (!ctr_up && ctr_q[wi] != '0)
               ctr_q[wi] <= ctr_q[wi] - 1'b1;
         end
         if (u_set) u_q[wi] <= 1'b1;
         if (u_clr) u_q[wi] <= 1'b0;
         if (alloc_en) begin
            tag_q[wi] <= wt;
            ctr_q[wi] <= alloc_up ? CTR_WT : CTR_WN;
            u_q[wi]   <= 1'b0;
         end
      end
   end

   // support state for the checks below
   logic             chk_ctr, chk_alloc;
   logic [IDX_W-1:0] chk_idx;
   logic [CTR_W-1:0] chk_old;
   logic [TAG_W-1:0] chk_tag;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_ctr <= 1'b0; chk_alloc <= 1'b0; chk_idx <= '0; chk_old <= '0; chk_tag <= '0;
      end else begin
         chk_ctr <= ctr_en; chk_alloc <= alloc_en; chk_idx <= wi;
         chk_old <= ctr_q[wi]; chk_tag <= wt;
      end
   end

   p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !(ctr_en || u_set || u_clr));

   p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_ctr |-> (ctr_q[chk_idx] == chk_old ||
                   ctr_q[chk_idx] == CTR_W'(chk_old + 1'b1) ||
                   ctr_q[chk_idx] == CTR_W'(chk_old - 1'b1)));

   p_alloc_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_alloc |-> (!u_q[chk_idx] && tag_q[chk_idx] == chk_tag));
endmodule

// File: rtl/geo_hist_predictor.sv
module geo_hist_predictor
   import geo_pred_pkg::*;
#(
   parameter int BASE_IDX_W = 8,
   parameter int TAB_IDX_W  = 6,
   parameter int TAG_W      = 8,
   parameter int CTR_W      = 3,
   parameter int HLEN1      = 4,
   parameter int HLEN2      = 8,
   parameter int HLEN3      = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [TAB_IDX_W+TAG_W-1:0] lk_pc,
   output logic                       lk_taken,
   output logic [1:0]                 lk_src,
   output logic [HLEN3-1:0]           lk_hist,
   input  logic                       up_valid,
   input  logic [TAB_IDX_W+TAG_W-1:0] up_pc,
   input  logic [HLEN3-1:0]           up_hist,
   input  logic                       up_taken
);
   localparam int NT   = NUM_TAGGED;
   localparam int GH_W = HLEN3;
   localparam int HLEN_TAB [NT] = '{HLEN1, HLEN2, HLEN3};

   if (!(HLEN1 < HLEN2 && HLEN2 < HLEN3)) begin : g_bad_order
      $error("history lengths must strictly grow");
   end
   if (HLEN2 * HLEN2 != HLEN1 * HLEN3) begin : g_bad_ratio
      $error("history lengths must form a geometric series");
   end
   if (BASE_IDX_W > TAB_IDX_W + TAG_W || TAG_W < 2 || CTR_W < 2) begin : g_bad_width
      $error("inconsistent table widths");
   end

   logic [GH_W-1:0] ghr_q;
   assign lk_hist = ghr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ghr_q <= '0;
      else if (up_valid) ghr_q <= {ghr_q[GH_W-2:0], up_taken};
   end

   logic          base_rd, base_wr, base_en;
   logic [NT-1:0] r_hit, r_pred, w_hit, w_pred, w_use;
   logic [NT-1:0] c_en, u_set, u_clr, al_en;

   geo_base_table #(.IDX_W(BASE_IDX_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_pc[BASE_IDX_W-1:0]),
      .rd_pred (base_rd),
      .wr_idx  (up_pc[BASE_IDX_W-1:0]),
      .wr_pred (base_wr),
      .ctr_en  (base_en),
      .ctr_up  (up_taken)
   );

   for (genvar g = 0; g < NT; g++) begin : g_bank
      geo_tag_bank #(
         .IDX_W (TAB_IDX_W),
         .TAG_W (TAG_W),
         .CTR_W (CTR_W),
         .HLEN  (HLEN_TAB[g])
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_pc     (lk_pc),
         .rd_hist   (ghr_q[HLEN_TAB[g]-1:0]),
         .rd_hit    (r_hit[g]),
         .rd_pred   (r_pred[g]),
         .wr_pc     (up_pc),
         .wr_hist   (up_hist[HLEN_TAB[g]-1:0]),
         .wr_hit    (w_hit[g]),
         .wr_pred   (w_pred[g]),
         .wr_useful (w_use[g]),
         .ctr_en    (c_en[g]),
         .ctr_up    (up_taken),
         .u_set     (u_set[g]),
         .u_clr     (u_clr[g]),
         .alloc_en  (al_en[g]),
         .alloc_up  (up_taken)
      );
   end

   // lookup: longest matching bank wins
   src_e lk_src_e;
   always_comb begin
      lk_src_e = SRC_BASE;
      lk_taken = base_rd;
      for (int t = 0; t < NT; t++) begin
         if (r_hit[t]) begin
            lk_src_e = src_e'(t + 1);
            lk_taken = r_pred[t];
         end
      end
   end
   assign lk_src = lk_src_e;

   // update: re-read with the snapshot, train, mark, claim
   int   prov;
   logic prov_pred, alt_pred, wrong, found;
   always_comb begin
      prov      = 0;
      prov_pred = base_wr;
      alt_pred  = base_wr;
      for (int t = 0; t < NT; t++) begin
         if (w_hit[t]) begin
            alt_pred  = prov_pred;
            prov_pred = w_pred[t];
            prov      = t + 1;
         end
      end
      wrong   = up_valid && (prov_pred != up_taken);
      base_en = up_valid && (prov == 0);
      found   = 1'b0;
      for (int t = 0; t < NT; t++) begin
         c_en[t]  = up_valid && (prov == t + 1);
         u_set[t] = up_valid && (prov == t + 1) && (prov_pred == up_taken) && (prov_pred != alt_pred);
         al_en[t] = 1'b0;
         if (wrong && (t + 1 > prov) && !w_use[t] && !found) begin
            al_en[t] = 1'b1;
            found    = 1'b1;
         end
      end
      for (int t = 0; t < NT; t++) u_clr[t] = wrong && (t + 1 > prov) && !found;
   end

   p_hist_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> (ghr_q[0] == $past(up_taken) && ghr_q[GH_W-1:1] == $past(ghr_q[GH_W-2:0])));

   p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(ghr_q));

   p_alloc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(al_en));

   p_clear_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (u_clr != '0) |-> (al_en == '0 && (u_clr & ~w_use) == '0));
endmodule

// File: tb/tb_geo_hist_predictor.sv
module tb_geo_hist_predictor;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [13:0] lk_pc;
   logic        lk_taken;
   logic [1:0]  lk_src;
   logic [15:0] lk_hist;
   logic        up_valid;
   logic [13:0] up_pc;
   logic [15:0] up_hist;
   logic        up_taken;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   geo_hist_predictor dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_src(lk_src),
      .lk_hist(lk_hist), .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
   );

   // ---------------- reference model ----------------
   int          mb [256];
   int          mc [3][64];
   int          mu [3][64];
   int          mt [3][64];
   logic [15:0] mg;
   int          hl [3] = '{4, 8, 16};

   function automatic int mfold(input logic [15:0] h, input int len, input int w);
      int r = 0;
      for (int k = 0; k < len; k++) if (h[k]) r = r ^ (1 << (k % w));
      return r;
   endfunction
   function automatic int m_idx(input int t, input logic [13:0] pc, input logic [15:0] h);
      return (int'(pc) & 63) ^ mfold(h, hl[t], 6);
   endfunction
   function automatic int m_tag(input int t, input logic [13:0] pc, input logic [15:0] h);
      return ((int'(pc) >> 6) & 255) ^ mfold(h, hl[t], 7);
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 256; i++) mb[i] = 1;
      for (int t = 0; t < 3; t++)
         for (int i = 0; i < 64; i++) begin mc[t][i] = 3; mu[t][i] = 0; mt[t][i] = 0; end
      mg = '0;
   endtask

   task automatic m_predict(input logic [13:0] pc, input logic [15:0] h,
                            output logic p, output int src, output logic alt);
      p = (mb[int'(pc) & 255] >= 2); alt = p; src = 0;
      for (int t = 0; t < 3; t++) begin
         int ix = m_idx(t, pc, h);
         if (mt[t][ix] == m_tag(t, pc, h)) begin alt = p; p = (mc[t][ix] >= 4); src = t + 1; end
      end
   endtask

   task automatic m_update(input logic [13:0] pc, input logic [15:0] h, input logic outc);
      logic p, alt; int src; bit done;
      m_predict(pc, h, p, src, alt);
      if (src == 0) begin
         int b = int'(pc) & 255;
         if (outc && mb[b] < 3) mb[b]++; else if (!outc && mb[b] > 0) mb[b]--;
      end else begin
         int ix = m_idx(src - 1, pc, h);
         if (outc && mc[src-1][ix] < 7) mc[src-1][ix]++;
         else if (!outc && mc[src-1][ix] > 0) mc[src-1][ix]--;
         if (p == outc && p != alt) mu[src-1][ix] = 1;
      end
      if (p != outc && src < 3) begin
         done = 0;
         for (int t = src; t < 3; t++) begin
            int ix = m_idx(t, pc, h);
            if (!done && mu[t][ix] == 0) begin
               mt[t][ix] = m_tag(t, pc, h); mc[t][ix] = outc ? 4 : 3; done = 1;
            end
         end
         if (!done) for (int t = src; t < 3; t++) mu[t][m_idx(t, pc, h)] = 0;
      end
      mg = {mg[14:0], outc};
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      logic        pred;
      logic [1:0]  src;
      logic [15:0] hist;
      logic        outc;
      bit          loopchk;
      string       req;
   } exp_t;
   exp_t q[$];

   task automatic step(input logic [13:0] lpc, input logic upv, input logic [13:0] upc,
                       input logic outc, input string req, input bit loopchk);
      exp_t e; logic p, a; int s;
      @(negedge clk);
      lk_pc = lpc;
      m_predict(lpc, mg, p, s, a);
      e.pred = p; e.src = 2'(s); e.hist = mg; e.outc = outc; e.loopchk = loopchk; e.req = req;
      q.push_back(e);
      up_valid = upv; up_pc = upc; up_hist = mg; up_taken = outc;
      if (upv) m_update(upc, mg, outc);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk); #5;
         if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (lk_taken !== e.pred || lk_src !== e.src || lk_hist !== e.hist) begin
               failures++;
               $display("FAIL %s: taken/src/hist actual %b/%0d/%h expected %b/%0d/%h",
                        e.req, lk_taken, lk_src, lk_hist, e.pred, e.src, e.hist);
            end
            if (e.loopchk) begin
               checks++;
               if (lk_taken !== e.outc) begin
                  failures++;
                  $display("FAIL R11: loop guess actual %b expected %b", lk_taken, e.outc);
               end
            end
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; up_valid = 1'b0;
      repeat (2) @(negedge clk);
      m_reset();
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   logic [15:0] lfsr = 16'hACE1;
   logic [13:0] pcs [8] = '{14'h0A11, 14'h1234, 14'h2F47, 14'h0B5C, 14'h3C03, 14'h17E8, 14'h2222, 14'h05A9};

   initial begin : driver
      lk_pc = '0; up_pc = '0; up_hist = '0; up_taken = 1'b0; up_valid = 1'b0; rst_n = 1'b0;
      m_reset();
      do_reset();
      // R1: reset state seen at the lookup port
      step(14'h0ABC, 1'b0, 14'h0, 1'b0, "R1", 0);
      // R5 R10: lookup with no update leaves history and tables alone
      step(14'h0ABC, 1'b0, 14'h0, 1'b0, "R5 R10", 0);
      // R2: not-taken stream, base table guesses right, nothing claimed
      for (int i = 0; i < 8; i++) step(pcs[i], 1'b1, pcs[i], 1'b0, "R2", 0);
      // R3 R4 R5 R6 R7 R8 R9 R10: mixed stream, lookup and update in the same cycle
      for (int i = 0; i < 600; i++) begin
         int sl, su; logic o;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sl = int'(lfsr[2:0]); su = int'(lfsr[5:3]);
         if (su < 4) o = mg[su] ^ su[0]; else o = lfsr[9];
         step(pcs[sl], 1'b1, pcs[su], o, "R3 R4 R5 R6 R7 R8 R9 R10", 0);
      end
      // R10: idle cycles keep the history
      for (int i = 0; i < 3; i++) step(pcs[i], 1'b0, pcs[i], 1'b1, "R10", 0);
      // R11: four-iteration loop from a clean reset
      do_reset();
      step(14'h0ABC, 1'b0, 14'h0, 1'b0, "R1", 0);
      for (int it = 0; it < 60; it++)
         for (int j = 0; j < 4; j++)
            step(14'h1ACD, 1'b1, 14'h1ACD, (j != 3), "R11", it >= 30);
      @(negedge clk); up_valid = 1'b0;
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule